// File: doc/BRIEF.md
# Split-Frame Doorbell Mailbox

This block passes doorbell notifications from a sending processor to a receiving processor. Each processor has its own register frame on a separate APB-style slave port with no wait states. The block has a build-time number of channels. Each channel holds a 32-bit status word. The sender raises bits in that word through its own frame. The receiver reads the same word through its frame and lowers the bits it has handled. While a channel's word is nonzero, that channel's interrupt line to the receiver stays high.

Each frame gives every channel a 32-byte window. Channel n starts at byte n*0x20. Channel 0 is the high-priority doorbell and channel 1 is the low-priority one. The sender frame also holds a read-only channel count and a wake handshake. The sender can ask the receiving domain's power controller to wake it, then watch for the receiver to report that it is awake. Withdrawing the request lets the receiver sleep. The block itself never commands sleep.

A port access takes effect in the access phase (psel and penable both high). A write lands on that clock edge. Read data is valid during the access phase and is zero when psel is low.

Top module: `dbell_mbox`

## Requirements
- R1: A sender write to channel offset 0xC ORs the write data into that channel's status word at the access-phase edge.
- R2: A receiver write to channel offset 0x8 clears, in that channel's status word, every bit that is 1 in the write data.
- R3: When a sender set and a receiver clear hit the same channel in the same cycle, the clear acts on the old value and the set then applies, so a bit that is 1 in both writes ends at 1.
- R4: Offset 0x0 of a channel window returns that channel's current status word in both frames, and both frames return the same value.
- R5: Receiver interrupt bit i is high exactly while channel i's status word is nonzero.
- R6: A sender read of 0xF80 returns the configured channel count NUM_CH. The same address reads 0 in the receiver frame.
- R7: A sender write to 0xF88 loads bit 0 of the data into the wake request. The request drives the wake_req output and reads back at 0xF88 in bit 0. Only a write to that address changes it.
- R8: A sender read of 0xF8C returns 1 in bit 0 only while the wake request is held and rcv_awake is high. Otherwise it returns 0.
- R9: Reads of unmapped or unaligned offsets, and of channels at or beyond NUM_CH, return 0. Writes to them are ignored. This covers a sender write to offset 0x8, a receiver write to offset 0xC, and receiver accesses to 0xF80 through 0xF8C.
- R10: After reset all status words are 0, the wake request is 0 and every interrupt is low.
- R11: Channels are independent. An access to the window at byte n*0x20 affects and reports only channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_psel | input | 1 | Sender port select |
| s_penable | input | 1 | Sender port access phase |
| s_pwrite | input | 1 | Sender port write strobe |
| s_paddr | input | 12 | Sender port byte address |
| s_pwdata | input | 32 | Sender port write data |
| s_prdata | output | 32 | Sender port read data |
| r_psel | input | 1 | Receiver port select |
| r_penable | input | 1 | Receiver port access phase |
| r_pwrite | input | 1 | Receiver port write strobe |
| r_paddr | input | 12 | Receiver port byte address |
| r_pwdata | input | 32 | Receiver port write data |
| r_prdata | output | 32 | Receiver port read data |
| rcv_awake | input | 1 | Receiver domain reports it is awake |
| wake_req | output | 1 | Wake request to the receiver power controller |
| rcv_irq | output | NUM_CH | Per-channel receiver interrupt |

## Verification
The bench goes after the collision of a sender set and a receiver clear in one cycle. A design that applied the clear last would lose the overlapping bits, and one that ignored either write would keep stale bits. It also probes the asymmetric offsets from the wrong side. A decoder shared between the two frames would let the sender clear bits or the receiver ring its own doorbell, and either would show up as a changed status word. Further checks cover an out-of-range channel that aliases onto a real one, wake-ready reporting 1 with no request held, and an interrupt that stays high after a partial clear empties the word.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int WIN_LSB = 5;                 // 32-byte channel windows
    localparam int CHIDX_W = ADDR_W - WIN_LSB;

    localparam logic [WIN_LSB-1:0] OFS_STAT = 5'h00;
    localparam logic [WIN_LSB-1:0] OFS_CLR  = 5'h08;
    localparam logic [WIN_LSB-1:0] OFS_SET  = 5'h0C;

    localparam logic [ADDR_W-1:0] ADR_CAP  = 12'hF80;
    localparam logic [ADDR_W-1:0] ADR_WREQ = 12'hF88;
    localparam logic [ADDR_W-1:0] ADR_WRDY = 12'hF8C;

    typedef enum logic [2:0] {
        K_NONE, K_STAT, K_SET, K_CLR, K_CAP, K_WREQ, K_WRDY
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic [CHIDX_W-1:0] ch;
    } dec_t;

    // Address decode for one frame; the sender flag selects the view.
    function automatic dec_t decode(input logic [ADDR_W-1:0] a,
                                    input logic              sender,
                                    input int unsigned       nch);
        dec_t d;
        d.kind = K_NONE;
        d.ch   = a[ADDR_W-1:WIN_LSB];
        if (sender && a == ADR_CAP)       d.kind = K_CAP;
        else if (sender && a == ADR_WREQ) d.kind = K_WREQ;
        else if (sender && a == ADR_WRDY) d.kind = K_WRDY;
        else if (32'(d.ch) < nch) begin
            if (a[WIN_LSB-1:0] == OFS_STAT)               d.kind = K_STAT;
            else if (sender && a[WIN_LSB-1:0] == OFS_SET)  d.kind = K_SET;
            else if (!sender && a[WIN_LSB-1:0] == OFS_CLR) d.kind = K_CLR;
        end
        return d;
    endfunction

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
#(
    parameter bit SENDER = 1'b1,
    parameter int NUM_CH = 2
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output dec_t              dec,
    output logic              wr_en
);
    always_comb begin
        dec   = decode(paddr, SENDER, NUM_CH);
        wr_en = psel && penable && pwrite;
    end
endmodule

// File: rtl/dbell_chan.sv
module dbell_chan
    import dbell_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [DATA_W-1:0] set_bits,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_bits,
    output logic [DATA_W-1:0] stat,
    output logic              irq
);
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] clr_mask;

    always_comb begin
        set_mask = set_en ? set_bits : '0;
        clr_mask = clr_en ? clr_bits : '0;
    end

    // Clear acts on the old word; the set is applied on top of it.
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_mask) | set_mask;
    end

    assign stat = stat_q;
    assign irq  = |stat_q;
endmodule

// File: rtl/dbell_wake.sv
module dbell_wake (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic awake,
    output logic req,
    output logic rdy
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst)        req_q <= 1'b0;
        else if (wr_en) req_q <= wr_bit;
    end

    assign req = req_q;
    assign rdy = req_q && awake;
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox
    import dbell_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_psel,
    input  logic              s_penable,
    input  logic              s_pwrite,
    input  logic [11:0]       s_paddr,
    input  logic [31:0]       s_pwdata,
    output logic [31:0]       s_prdata,
    input  logic              r_psel,
    input  logic              r_penable,
    input  logic              r_pwrite,
    input  logic [11:0]       r_paddr,
    input  logic [31:0]       r_pwdata,
    output logic [31:0]       r_prdata,
    input  logic              rcv_awake,
    output logic              wake_req,
    output logic [NUM_CH-1:0] rcv_irq
);
    localparam int MAX_CH = 32'(ADR_CAP) >> WIN_LSB;

    initial begin
        if (NUM_CH < 1 || NUM_CH > MAX_CH)
            $error("NUM_CH out of range");
    end

    dec_t s_dec, r_dec;
    logic s_wr, r_wr;
    logic wrdy;
    logic [DATA_W-1:0]        stat [NUM_CH];
    logic [NUM_CH*DATA_W-1:0] stat_flat;
    logic [DATA_W-1:0]        s_stat_sel, r_stat_sel;

    dbell_decode #(.SENDER(1'b1), .NUM_CH(NUM_CH)) s_dec_i (
        .psel(s_psel), .penable(s_penable), .pwrite(s_pwrite),
        .paddr(s_paddr), .dec(s_dec), .wr_en(s_wr)
    );

    dbell_decode #(.SENDER(1'b0), .NUM_CH(NUM_CH)) r_dec_i (
        .psel(r_psel), .penable(r_penable), .pwrite(r_pwrite),
        .paddr(r_paddr), .dec(r_dec), .wr_en(r_wr)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic set_hit, clr_hit;
        assign set_hit = s_wr && s_dec.kind == K_SET && s_dec.ch == CHIDX_W'(i);
        assign clr_hit = r_wr && r_dec.kind == K_CLR && r_dec.ch == CHIDX_W'(i);

        dbell_chan chan_i (
            .clk(clk), .rst(rst),
            .set_en(set_hit), .set_bits(s_pwdata),
            .clr_en(clr_hit), .clr_bits(r_pwdata),
            .stat(stat[i]), .irq(rcv_irq[i])
        );
        assign stat_flat[i*DATA_W +: DATA_W] = stat[i];
    end

    dbell_wake wake_i (
        .clk(clk), .rst(rst),
        .wr_en(s_wr && s_dec.kind == K_WREQ),
        .wr_bit(s_pwdata[0]),
        .awake(rcv_awake),
        .req(wake_req), .rdy(wrdy)
    );

    always_comb begin
        s_stat_sel = '0;
        r_stat_sel = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (s_dec.ch == CHIDX_W'(i)) s_stat_sel = stat[i];
            if (r_dec.ch == CHIDX_W'(i)) r_stat_sel = stat[i];
        end
    end

    always_comb begin
        s_prdata = '0;
        if (s_psel) begin
            unique case (s_dec.kind)
                K_STAT:  s_prdata = s_stat_sel;
                K_CAP:   s_prdata = DATA_W'(NUM_CH);
                K_WREQ:  s_prdata = {{(DATA_W-1){1'b0}}, wake_req};
                K_WRDY:  s_prdata = {{(DATA_W-1){1'b0}}, wrdy};
                default: s_prdata = '0;
            endcase
        end
    end

    always_comb begin
        r_prdata = '0;
        if (r_psel && r_dec.kind == K_STAT) r_prdata = r_stat_sel;
    end
endmodule

// File: rtl/dbell_mbox_chk.sv
module dbell_mbox_chk #(
    parameter int NUM_CH = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 s_psel,
    input logic                 s_penable,
    input logic                 s_pwrite,
    input logic [11:0]          s_paddr,
    input logic [31:0]          s_pwdata,
    input logic [31:0]          s_prdata,
    input logic                 r_psel,
    input logic                 r_penable,
    input logic                 r_pwrite,
    input logic [11:0]          r_paddr,
    input logic [31:0]          r_pwdata,
    input logic                 rcv_awake,
    input logic                 wake_req,
    input logic [NUM_CH-1:0]    rcv_irq,
    input logic [NUM_CH*32-1:0] stat_flat
);
    logic s_wr, r_wr, s_set0, r_clr0;
    assign s_wr   = s_psel && s_penable && s_pwrite;
    assign r_wr   = r_psel && r_penable && r_pwrite;
    assign s_set0 = s_wr && s_paddr == 12'h00C;
    assign r_clr0 = r_wr && r_paddr == 12'h008;

    AST_SET_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (s_set0 && s_pwdata != 32'h0) |=> rcv_irq[0]); // R1

    AST_FULL_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (r_clr0 && r_pwdata == 32'hFFFF_FFFF && !s_set0) |=> !rcv_irq[0]); // R2

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (s_set0 && r_clr0 && s_pwdata != 32'h0) |=> rcv_irq[0]); // R3

    AST_IDLE_KEEPS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (!s_wr && !r_wr) |=> $stable(stat_flat)); // R9

    AST_WAKE_REQ_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(s_wr && s_paddr == 12'hF88) |=> $stable(wake_req)); // R7

    AST_READY_NEEDS_REQ_AND_AWAKE: assert property (@(posedge clk) disable iff (rst)
        (s_psel && !s_pwrite && s_paddr == 12'hF8C)
        |-> (s_prdata == {31'h0, wake_req && rcv_awake})); // R8

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (rcv_irq == '0 && !wake_req)); // R10
endmodule

bind dbell_mbox dbell_mbox_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk(clk), .rst(rst),
    .s_psel(s_psel), .s_penable(s_penable), .s_pwrite(s_pwrite),
    .s_paddr(s_paddr), .s_pwdata(s_pwdata), .s_prdata(s_prdata),
    .r_psel(r_psel), .r_penable(r_penable), .r_pwrite(r_pwrite),
    .r_paddr(r_paddr), .r_pwdata(r_pwdata),
    .rcv_awake(rcv_awake), .wake_req(wake_req),
    .rcv_irq(rcv_irq), .stat_flat(stat_flat)
);

// File: tb/dbell_mbox_tb_top.sv
module dbell_mbox_tb_top;
    localparam int CLK_P  = 10;
    localparam int NUM_CH = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic s_psel = 0, s_penable = 0, s_pwrite = 0;
    logic [11:0] s_paddr = '0;
    logic [31:0] s_pwdata = '0;
    logic [31:0] s_prdata;
    logic r_psel = 0, r_penable = 0, r_pwrite = 0;
    logic [11:0] r_paddr = '0;
    logic [31:0] r_pwdata = '0;
    logic [31:0] r_prdata;
    logic rcv_awake = 1'b0;
    logic wake_req;
    logic [NUM_CH-1:0] rcv_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    int          req_q[$];

    always #(CLK_P/2) clk = ~clk;

    dbell_mbox #(.NUM_CH(NUM_CH)) dut_i (
        .clk(clk), .rst(rst),
        .s_psel(s_psel), .s_penable(s_penable), .s_pwrite(s_pwrite),
        .s_paddr(s_paddr), .s_pwdata(s_pwdata), .s_prdata(s_prdata),
        .r_psel(r_psel), .r_penable(r_penable), .r_pwrite(r_pwrite),
        .r_paddr(r_paddr), .r_pwdata(r_pwdata), .r_prdata(r_prdata),
        .rcv_awake(rcv_awake), .wake_req(wake_req), .rcv_irq(rcv_irq)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each read in its access phase against the scoreboard.
    always @(negedge clk) begin
        if (!rst) begin
            if ((s_psel && s_penable && !s_pwrite) || (r_psel && r_penable && !r_pwrite)) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R4 actual=unexpected-read expected=none");
                end else begin
                    check(req_q.pop_front(),
                          s_psel ? s_prdata : r_prdata,
                          exp_q.pop_front());
                end
            end
        end
    end

    // Driver: one access on a chosen port (sender when snd=1).
    task automatic xfer(input bit snd, input bit wr, input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        if (snd) begin s_psel = 1; s_pwrite = wr; s_paddr = a; s_pwdata = d; end
        else     begin r_psel = 1; r_pwrite = wr; r_paddr = a; r_pwdata = d; end
        @(posedge clk); #1;
        if (snd) s_penable = 1; else r_penable = 1;
        @(posedge clk); #1;
        s_psel = 0; s_penable = 0; s_pwrite = 0;
        r_psel = 0; r_penable = 0; r_pwrite = 0;
    endtask

    task automatic wr(input bit snd, input logic [11:0] a, input logic [31:0] d);
        xfer(snd, 1'b1, a, d);
    endtask

    task automatic rd(input bit snd, input logic [11:0] a, input logic [31:0] exp, input int req);
        exp_q.push_back(exp);
        req_q.push_back(req);
        xfer(snd, 1'b0, a, 32'h0);
    endtask

    // Sender set and receiver clear landing on the same edge.
    task automatic both_wr(input logic [11:0] sa, input logic [31:0] sd,
                           input logic [11:0] ra, input logic [31:0] rd_);
        @(posedge clk); #1;
        s_psel = 1; s_pwrite = 1; s_paddr = sa; s_pwdata = sd;
        r_psel = 1; r_pwrite = 1; r_paddr = ra; r_pwdata = rd_;
        @(posedge clk); #1;
        s_penable = 1; r_penable = 1;
        @(posedge clk); #1;
        s_psel = 0; s_penable = 0; s_pwrite = 0;
        r_psel = 0; r_penable = 0; r_pwrite = 0;
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R10 actual=watchdog-timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R10: idle after reset
        check(10, 32'(rcv_irq), 32'h0);
        check(10, 32'(wake_req), 32'h0);
        rd(1, 12'h000, 32'h0, 10);           // R10
        rd(1, 12'h020, 32'h0, 10);           // R10

        // R6: capability only in sender frame
        rd(1, 12'hF80, 32'(NUM_CH), 6);      // R6
        rd(0, 12'hF80, 32'h0, 6);            // R6

        // R1 / R4 / R5: set accumulates, both frames agree
        wr(1, 12'h00C, 32'h0000_0005);
        rd(1, 12'h000, 32'h0000_0005, 1);    // R1
        wr(1, 12'h00C, 32'h0000_0030);
        rd(1, 12'h000, 32'h0000_0035, 1);    // R1
        rd(0, 12'h000, 32'h0000_0035, 4);    // R4
        check(5, 32'(rcv_irq), 32'h1);       // R5

        // R11: channel 1 window is separate
        wr(1, 12'h02C, 32'hA000_0000);
        rd(0, 12'h020, 32'hA000_0000, 11);   // R11
        rd(1, 12'h000, 32'h0000_0035, 11);   // R11
        check(11, 32'(rcv_irq), 32'h3);      // R11

        // R2 / R5: partial clear keeps irq, full clear drops it
        wr(0, 12'h008, 32'h0000_0005);
        rd(0, 12'h000, 32'h0000_0030, 2);    // R2
        check(5, 32'(rcv_irq), 32'h3);       // R5
        wr(0, 12'h008, 32'h0000_0030);
        rd(1, 12'h000, 32'h0, 2);            // R2
        check(5, 32'(rcv_irq), 32'h2);       // R5
        wr(0, 12'h028, 32'hFFFF_FFFF);
        check(5, 32'(rcv_irq), 32'h0);       // R5

        // R3: old 0x0F, clear 0x33 -> 0x0C, then set 0x3C -> 0x3C
        wr(1, 12'h00C, 32'h0000_000F);
        both_wr(12'h00C, 32'h0000_003C, 12'h008, 32'h0000_0033);
        rd(1, 12'h000, 32'h0000_003C, 3);    // R3

        // R9: wrong-side offsets, unmapped, out-of-range channel
        wr(1, 12'h008, 32'hFFFF_FFFF);
        wr(0, 12'h00C, 32'h0000_FF00);
        rd(0, 12'h000, 32'h0000_003C, 9);    // R9
        rd(1, 12'h004, 32'h0, 9);            // R9
        rd(1, 12'h00C, 32'h0, 9);            // R9
        wr(1, 12'h04C, 32'h0000_0001);
        rd(1, 12'h040, 32'h0, 9);            // R9
        rd(0, 12'h020, 32'h0, 9);            // R9
        check(9, 32'(rcv_irq), 32'h1);       // R9
        wr(0, 12'hF88, 32'h1);
        check(9, 32'(wake_req), 32'h0);      // R9
        rd(0, 12'hF88, 32'h0, 9);            // R9
        rd(1, 12'h00D, 32'h0, 9);            // R9

        // R7 / R8: wake handshake
        rd(1, 12'hF8C, 32'h0, 8);            // R8
        wr(1, 12'hF88, 32'h1);
        check(7, 32'(wake_req), 32'h1);      // R7
        rd(1, 12'hF88, 32'h1, 7);            // R7
        rd(1, 12'hF8C, 32'h0, 8);            // R8
        rcv_awake = 1'b1;
        rd(1, 12'hF8C, 32'h1, 8);            // R8
        wr(1, 12'hF88, 32'h0);
        check(7, 32'(wake_req), 32'h0);      // R7
        rd(1, 12'hF8C, 32'h0, 8);            // R8

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R4 actual=%0d pending expected=0", exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule